// File: doc/BRIEF.md
# Multi-Format Serial Audio Input Receiver

This block takes a two-channel audio stream carried on three lines: a bit clock, a word-select line and a data line. It turns the stream into parallel samples, one per channel. A static format input chooses one of four framings:

- delayed-MSB level framing (I2S)
- undelayed level framing (left-justified)
- pulse framing in which a short word-select pulse introduces each word
- a packed framing in which a 16-bit word exactly fills its half-frame

A second static input chooses 16-bit or 18-bit words. All three serial lines are oversampled by the system clock through two-flop synchronizers, and the bit-clock edges are found inside the block. A finished word appears on the left or right output register together with a one-cycle strobe for that channel. A word is delivered when the first bit of the following word is sampled, so the boundary is known with certainty.

The system clock must run at least four times faster than the bit clock. The transmitter changes data half a bit period away from the sampling edge. Changes to the format and word-length inputs are held back until the next left-channel word begins. That start is recognised under the old setting, and the word in progress at that moment is dropped.

Top module: `serial_audio_rx`

## Requirements
- R1: With `fmt_i` = 0 (I2S), word-select low carries the left word and high the right word. Data is taken on rising bit-clock edges, and the MSB is the bit one bit period after the word-select change.
- R2: With `fmt_i` = 1 (left-justified), word-select high carries the left word and low the right word. Data is taken on rising edges, and the bit sampled together with the word-select change is the MSB.
- R3: With `fmt_i` = 2 (pulse framing), data is taken on falling edges. A word-select high sample marks a pulse, and the first low sample after it carries the MSB. After reset the first pulse introduces a left word, and channels then alternate left, right, left regardless of word-select level.
- R4: With `fmt_i` = 3 (packed), framing follows R2 (high = left, rising edge, no delay). The word length is always 16 bits whatever `wlen18_i` says.
- R5: With `wlen18_i` = 1 (outside packed format), all 18 bits are kept, the MSB landing in output bit 17.
- R6: With 16-bit words, the word occupies output bits 17..2 and bits 1..0 are zero.
- R7: Bits that arrive after the selected word length within one half-frame have no effect on the delivered word.
- R8: When a half-frame ends before the word is complete, the missing low bits are delivered as zeros.
- R9: A word is delivered only once the first bit of the next word has been sampled. Delivery loads the matching channel register and raises that channel's strobe for exactly one system clock. The registers hold their value between strobes.
- R10: Synchronous active-low reset clears both sample registers, both strobes and the bit count. In pulse framing it also makes the next pulse a left word.
- R11: A change of `fmt_i` or `wlen18_i` takes effect at the next left-word start detected under the old setting. The word in progress at that point is discarded, not delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| ws_i | input | 1 | Word-select line (asynchronous) |
| sdata_i | input | 1 | Serial data line (asynchronous) |
| fmt_i | input | 2 | Framing: 0 I2S, 1 left-justified, 2 pulse, 3 packed |
| wlen18_i | input | 1 | 1 selects 18-bit words, 0 selects 16-bit words |
| left_o | output | 18 | Last delivered left sample, MSB at bit 17 |
| left_vld_o | output | 1 | One-cycle strobe when `left_o` is loaded |
| right_o | output | 18 | Last delivered right sample, MSB at bit 17 |
| right_vld_o | output | 1 | One-cycle strobe when `right_o` is loaded |

## Verification
The hardest situation to reach is a format change while a word is half assembled. The discard only happens when the old framing rule sees a left start, and the new framing gives that event a different meaning. The bench gets there by switching from left-justified to I2S before a right word. It then plays I2S half-frames until the level rise, which the old rule reads as a left start, adopts the new setting. It checks that the stale right word never appears and that the next full I2S frame is delivered intact. A second hard case is the pulse-framing channel tracker. It is reached by resetting after an odd number of pulses and confirming that the following pulse still lands on the left output.

// File: rtl/sarx_pkg.sv
// Shared types for the serial audio receiver.
package sarx_pkg;

    // Framing selector; the numeric values are the fmt_i encoding.
    typedef enum logic [1:0] {
        FMT_I2S    = 2'd0,
        FMT_LJ     = 2'd1,
        FMT_DSP    = 2'd2,
        FMT_PACKED = 2'd3
    } sarx_fmt_e;

    // Channel tag carried with each word.
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } sarx_chan_e;

endpackage

// File: rtl/sarx_sync.sv
// sarx_sync: brings W asynchronous lines into the clk domain through a
// chain of STAGES flops each, and also gives the synchronised value one
// cycle older so that edges can be found downstream.
// Assumes the lines change no faster than every two clk cycles.
module sarx_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);

    logic [W-1:0] prev_q;

    for (genvar b = 0; b < W; b++) begin : g_line
        logic [STAGES-1:0] stg_q;

        // Shift the raw line through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) stg_q <= '0;
            else        stg_q <= {stg_q[STAGES-2:0], async_i[b]};
        end

        assign sync_o[b] = stg_q[STAGES-1];
    end

    // Keep the previous synchronised value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_o;
    end

    assign prev_o = prev_q;

endmodule

// File: rtl/sarx_framer.sv
// sarx_framer: turns synchronised bit-clock, word-select and data into
// per-bit commands for the word assembler. On each sampling edge of the
// active framing it asks either to append the bit to the current word
// (take_o) or to begin a new word with it (start_o, with its channel).
// clr_i abandons any armed start and re-arms the pulse-mode tracker on
// the left channel. Assumes the inputs come from sarx_sync.
module sarx_framer
    import sarx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sarx_fmt_e  fmt_i,
    input  logic       clr_i,
    input  logic       bclk_s_i,
    input  logic       bclk_d_i,
    input  logic       ws_s_i,
    input  logic       sd_s_i,
    output logic       take_o,
    output logic       start_o,
    output sarx_chan_e chan_o,
    output logic       bit_o
);

    logic       rise;
    logic       fall;
    logic       evt;
    logic       ws_chg;
    logic       ws_prev_q;
    logic       armed_q;
    sarx_chan_e arm_chan_q;
    sarx_chan_e trk_q;

    assign rise   = bclk_s_i & ~bclk_d_i;
    assign fall   = ~bclk_s_i & bclk_d_i;
    assign evt    = (fmt_i == FMT_DSP) ? fall : rise;
    assign ws_chg = ws_s_i ^ ws_prev_q;
    assign bit_o  = sd_s_i;

    // Decode the framing rule for the current sampling edge.
    always_comb begin
        take_o  = 1'b0;
        start_o = 1'b0;
        chan_o  = CH_LEFT;
        if (evt) begin
            unique case (fmt_i)
                FMT_I2S: begin
                    if (ws_chg)       take_o = 1'b1;
                    else if (armed_q) begin
                        start_o = 1'b1;
                        chan_o  = arm_chan_q;
                    end else          take_o = 1'b1;
                end
                FMT_DSP: begin
                    if (ws_s_i)       take_o = 1'b0;
                    else if (armed_q) begin
                        start_o = 1'b1;
                        chan_o  = trk_q;
                    end else          take_o = 1'b1;
                end
                default: begin
                    if (ws_chg) begin
                        start_o = 1'b1;
                        chan_o  = ws_s_i ? CH_LEFT : CH_RIGHT;
                    end else take_o = 1'b1;
                end
            endcase
        end
    end

    // Track word-select history, pending starts and the pulse-mode channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_prev_q  <= 1'b0;
            armed_q    <= 1'b0;
            arm_chan_q <= CH_LEFT;
            trk_q      <= CH_LEFT;
        end else begin
            if (evt) ws_prev_q <= ws_s_i;
            if (clr_i) begin
                armed_q <= 1'b0;
                trk_q   <= CH_LEFT;
            end else if (evt) begin
                unique case (fmt_i)
                    FMT_I2S: begin
                        if (ws_chg) begin
                            armed_q    <= 1'b1;
                            arm_chan_q <= ws_s_i ? CH_RIGHT : CH_LEFT;
                        end else if (armed_q) begin
                            armed_q <= 1'b0;
                        end
                    end
                    FMT_DSP: begin
                        if (ws_s_i) begin
                            armed_q <= 1'b1;
                        end else if (armed_q) begin
                            armed_q <= 1'b0;
                            trk_q   <= (trk_q == CH_LEFT) ? CH_RIGHT : CH_LEFT;
                        end
                    end
                    default: armed_q <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/sarx_word_asm.sv
// sarx_word_asm: assembles bits into a SAMPLE_W-wide word, MSB first and
// left-aligned, keeping at most SAMPLE_W or SHORT_W bits. Unfilled bits
// stay zero. When a new word starts, the finished one is copied to its
// channel's output register with a one-cycle strobe. drop_i discards the
// word in progress without delivering it.
module sarx_word_asm
    import sarx_pkg::*;
#(
    parameter int SAMPLE_W = 18,
    parameter int SHORT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                long_i,
    input  logic                take_i,
    input  logic                start_i,
    input  sarx_chan_e          chan_i,
    input  logic                bit_i,
    input  logic                drop_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic                left_vld_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                right_vld_o
);

    localparam int CNT_W = $clog2(SAMPLE_W + 1);
    localparam logic [SAMPLE_W-1:0] MSB_ONE = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic [SAMPLE_W-1:0] acc_q;
    logic [CNT_W-1:0]    cnt_q;
    logic                act_q;
    sarx_chan_e          chan_q;
    logic [CNT_W-1:0]    limit;
    logic [SAMPLE_W-1:0] pos_mask;
    logic                emit;
    logic [SAMPLE_W-1:0] word_arr [2];
    logic [1:0]          vld_arr;

    assign limit    = long_i ? CNT_W'(SAMPLE_W) : CNT_W'(SHORT_W);
    assign pos_mask = MSB_ONE >> cnt_q;
    assign emit     = start_i & act_q & ~drop_i;

    // Accumulate bits of the current word and open new words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            cnt_q  <= '0;
            act_q  <= 1'b0;
            chan_q <= CH_LEFT;
        end else if (drop_i) begin
            acc_q <= '0;
            cnt_q <= '0;
            act_q <= 1'b0;
        end else if (start_i) begin
            acc_q  <= bit_i ? MSB_ONE : '0;
            cnt_q  <= CNT_W'(1);
            act_q  <= 1'b1;
            chan_q <= chan_i;
        end else if (take_i && act_q && (cnt_q < limit)) begin
            if (bit_i) acc_q <= acc_q | pos_mask;
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    for (genvar c = 0; c < 2; c++) begin : g_chan
        logic [SAMPLE_W-1:0] word_q;
        logic                vld_q;

        // Load this channel's register and pulse its strobe on delivery.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
                vld_q  <= 1'b0;
            end else begin
                vld_q <= emit && (chan_q == sarx_chan_e'(c));
                if (emit && (chan_q == sarx_chan_e'(c))) word_q <= acc_q;
            end
        end

        assign word_arr[c] = word_q;
        assign vld_arr[c]  = vld_q;
    end

    assign left_o      = word_arr[0];
    assign left_vld_o  = vld_arr[0];
    assign right_o     = word_arr[1];
    assign right_vld_o = vld_arr[1];

endmodule

// File: rtl/serial_audio_rx.sv
// serial_audio_rx: multi-format serial audio input receiver. It
// synchronises the three serial lines, applies the selected framing rule
// and assembles left/right words with per-channel strobes. fmt_i and
// wlen18_i are latched at reset and otherwise adopted only at a
// left-word start seen under the current rule, discarding that word.
// Assumes clk runs at least 4x the bit clock.
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int SAMPLE_W    = 18,
    parameter int SHORT_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_i,
    input  logic                ws_i,
    input  logic                sdata_i,
    input  logic [1:0]          fmt_i,
    input  logic                wlen18_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic                left_vld_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                right_vld_o
);

    logic [2:0] line_s;
    logic [2:0] line_d;
    sarx_fmt_e  req_fmt;
    sarx_fmt_e  act_fmt_q;
    logic       act_w18_q;
    logic       pend;
    logic       adopt;
    logic       long_w;
    logic       f_take;
    logic       f_start;
    sarx_chan_e f_chan;
    logic       f_bit;

    assign req_fmt = sarx_fmt_e'(fmt_i);
    assign pend    = (req_fmt != act_fmt_q) || (wlen18_i != act_w18_q);
    assign adopt   = pend && f_start && (f_chan == CH_LEFT);
    assign long_w  = act_w18_q && (act_fmt_q != FMT_PACKED);

    // Hold the active configuration; take a new one only at a left start.
    always_ff @(posedge clk) begin
        if (!rst_n || adopt) begin
            act_fmt_q <= req_fmt;
            act_w18_q <= wlen18_i;
        end
    end

    sarx_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdata_i, ws_i, bclk_i}),
        .sync_o  (line_s),
        .prev_o  (line_d)
    );

    sarx_framer u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt_i    (act_fmt_q),
        .clr_i    (adopt),
        .bclk_s_i (line_s[0]),
        .bclk_d_i (line_d[0]),
        .ws_s_i   (line_s[1]),
        .sd_s_i   (line_s[2]),
        .take_o   (f_take),
        .start_o  (f_start),
        .chan_o   (f_chan),
        .bit_o    (f_bit)
    );

    sarx_word_asm #(
        .SAMPLE_W (SAMPLE_W),
        .SHORT_W  (SHORT_W)
    ) u_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .long_i      (long_w),
        .take_i      (f_take),
        .start_i     (f_start),
        .chan_i      (f_chan),
        .bit_i       (f_bit),
        .drop_i      (adopt),
        .left_o      (left_o),
        .left_vld_o  (left_vld_o),
        .right_o     (right_o),
        .right_vld_o (right_vld_o)
    );

endmodule

// File: rtl/sarx_checks.sv
// sarx_checks: property checks for serial_audio_rx, bound to every
// instance of it below.
module sarx_checks
    import sarx_pkg::*;
#(
    parameter int SAMPLE_W = 18,
    parameter int SHORT_W  = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [SAMPLE_W-1:0] left_o,
    input logic                left_vld_o,
    input logic [SAMPLE_W-1:0] right_o,
    input logic                right_vld_o,
    input sarx_fmt_e           act_fmt,
    input logic                act_w18
);

    localparam int LOW_W = SAMPLE_W - SHORT_W;

    logic       was_rst_q;
    sarx_chan_e last_q;
    logic       short_cfg;

    assign short_cfg = !act_w18 || (act_fmt == FMT_PACKED);

    // Remember whether the previous cycle was in reset.
    always_ff @(posedge clk) was_rst_q <= !rst_n;

    // Remember the channel of the last delivery in pulse framing.
    always_ff @(posedge clk) begin
        if (!rst_n || act_fmt != FMT_DSP) last_q <= CH_RIGHT;
        else if (left_vld_o)              last_q <= CH_LEFT;
        else if (right_vld_o)             last_q <= CH_RIGHT;
    end

    // R10: first cycle out of reset shows cleared outputs.
    a_r10_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst_q |-> (left_o == '0 && right_o == '0 && !left_vld_o && !right_vld_o));

    // R9: strobes last a single cycle.
    a_r9_left_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        left_vld_o |=> !left_vld_o);
    a_r9_right_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        right_vld_o |=> !right_vld_o);

    // R9: registers hold between strobes.
    a_r9_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !left_vld_o |-> $stable(left_o));
    a_r9_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !right_vld_o |-> $stable(right_o));

    // R6 / R4: short words leave the low bits clear.
    a_r6_left_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (left_vld_o && short_cfg) |-> (left_o[LOW_W-1:0] == '0));
    a_r6_right_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (right_vld_o && short_cfg) |-> (right_o[LOW_W-1:0] == '0));

    // R3: pulse framing alternates channels starting with left.
    a_r3_left_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (act_fmt == FMT_DSP && left_vld_o) |-> (last_q == CH_RIGHT));
    a_r3_right_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (act_fmt == FMT_DSP && right_vld_o) |-> (last_q == CH_LEFT));

endmodule

bind serial_audio_rx sarx_checks #(
    .SAMPLE_W (SAMPLE_W),
    .SHORT_W  (SHORT_W)
) u_sarx_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .left_o      (left_o),
    .left_vld_o  (left_vld_o),
    .right_o     (right_o),
    .right_vld_o (right_vld_o),
    .act_fmt     (act_fmt_q),
    .act_w18     (act_w18_q)
);

// File: tb/serial_audio_rx_bench.sv
`timescale 1ns/1ps
module serial_audio_rx_bench;

    localparam int F_I2S = 0;
    localparam int F_LJ  = 1;
    localparam int F_DSP = 2;
    localparam int F_PK  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_i = 1'b0;
    logic        ws_i = 1'b0;
    logic        sdata_i = 1'b0;
    logic [1:0]  fmt_i = 2'd0;
    logic        wlen18_i = 1'b0;
    logic [17:0] left_o;
    logic        left_vld_o;
    logic [17:0] right_o;
    logic        right_vld_o;

    int          n_checks = 0;
    int          n_errors = 0;
    int          n_left = 0;
    int          n_right = 0;
    logic [17:0] last_left = '0;
    logic [17:0] last_right = '0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    serial_audio_rx u_serial_audio_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_i      (bclk_i),
        .ws_i        (ws_i),
        .sdata_i     (sdata_i),
        .fmt_i       (fmt_i),
        .wlen18_i    (wlen18_i),
        .left_o      (left_o),
        .left_vld_o  (left_vld_o),
        .right_o     (right_o),
        .right_vld_o (right_vld_o)
    );

    // Record deliveries away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (left_vld_o)  begin n_left++;  last_left  <= left_o;  end
            if (right_vld_o) begin n_right++; last_right <= right_o; end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [17:0] exp_word(input logic [17:0] w, input int keep);
        logic [17:0] r = '0;
        for (int i = 0; i < 18; i++) if (i < keep) r[17-i] = w[17-i];
        return r;
    endfunction

    task automatic do_reset(input int fmt, input logic w18);
        @(negedge clk);
        rst_n = 1'b0; fmt_i = 2'(fmt); wlen18_i = w18;
        bclk_i = 1'b0; ws_i = 1'b0; sdata_i = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bit(input bit dsp, input logic ws, input logic d);
        if (dsp) begin
            bclk_i = 1'b1; ws_i = ws; sdata_i = d;
            repeat (4) @(negedge clk);
            bclk_i = 1'b0;
            repeat (4) @(negedge clk);
        end else begin
            ws_i = ws; sdata_i = d;
            repeat (4) @(negedge clk);
            bclk_i = 1'b1;
            repeat (4) @(negedge clk);
            bclk_i = 1'b0;
        end
    endtask

    task automatic send_half(input int fmt, input bit left, input logic [17:0] w,
                             input int nbits, input int slot);
        bit   dly = (fmt == F_I2S) || (fmt == F_DSP);
        logic lvl = (fmt == F_I2S) ? ~left : left;
        for (int p = 0; p < slot; p++) begin
            int   k = dly ? p - 1 : p;
            logic d = (k >= 0 && k < nbits) ? w[17-k] : 1'b0;
            logic ws = (fmt == F_DSP) ? (p == 0) : lvl;
            send_bit(fmt == F_DSP, ws, d);
        end
    endtask

    // Primer (not for pulse framing), two frames, trailing left half.
    task automatic stream(input string req, input int fmt, input int slot, input int nbits,
                          input int len, input logic [17:0] l1, input logic [17:0] r1,
                          input logic [17:0] l2, input logic [17:0] r2);
        int l0 = n_left;
        int r0 = n_right;
        int avail = ((fmt == F_I2S) || (fmt == F_DSP)) ? slot - 1 : slot;
        int keep = (nbits < avail) ? nbits : avail;
        if (len < keep) keep = len;
        if (fmt != F_DSP) send_half(fmt, 0, r1, nbits, slot);
        send_half(fmt, 1, l1, nbits, slot);
        check({req, " R9 no early delivery"}, n_left - l0, 0);
        send_half(fmt, 0, r1, nbits, slot);
        send_half(fmt, 1, l2, nbits, slot);
        send_half(fmt, 0, r2, nbits, slot);
        send_half(fmt, 1, 18'h0, nbits, slot);
        repeat (10) @(negedge clk);
        check({req, " left value"},  last_left,  exp_word(l2, keep));
        check({req, " right value"}, last_right, exp_word(r2, keep));
        check({req, " left count"},  n_left - l0, 2);
        check({req, " right count"}, n_right - r0, (fmt == F_I2S) ? 3 : 2);
    endtask

    task automatic t_reset();
        do_reset(F_LJ, 1'b1);
        check("R10 left_o", left_o, 0);
        check("R10 right_o", right_o, 0);
        check("R10 left_vld_o", left_vld_o, 0);
        check("R10 right_vld_o", right_vld_o, 0);
    endtask

    task automatic t_i2s();
        do_reset(F_I2S, 1'b1);
        stream("R1 R5 i2s 18b", F_I2S, 32, 18, 18, 18'h2A5C3, 18'h15A3C, 18'h3F00F, 18'h0C3A5);
    endtask

    task automatic t_lj();
        do_reset(F_LJ, 1'b0);
        stream("R2 R6 lj 16b", F_LJ, 24, 16, 16, 18'h2B57C, 18'h1D2E4, 18'h35A94, 18'h0F0F0);
    endtask

    task automatic t_dsp();
        do_reset(F_DSP, 1'b1);
        stream("R3 dsp 18b", F_DSP, 20, 18, 18, 18'h3A5A5, 18'h05A5B, 18'h2C0F3, 18'h1B3D7);
    endtask

    task automatic t_packed();
        do_reset(F_PK, 1'b0);
        stream("R4 packed", F_PK, 16, 16, 16, 18'h3ABC0, 18'h12344, 18'h2F0F0, 18'h0ACE4);
    endtask

    task automatic t_packed_force();
        do_reset(F_PK, 1'b1);
        stream("R4 packed forces 16b", F_PK, 20, 18, 16, 18'h3FFFF, 18'h2AAAB, 18'h15557, 18'h3C3C3);
    endtask

    task automatic t_extra();
        do_reset(F_I2S, 1'b0);
        stream("R7 extra bits ignored", F_I2S, 32, 18, 16, 18'h3FFFF, 18'h2D5AB, 18'h1A5A7, 18'h33333);
    endtask

    task automatic t_short();
        do_reset(F_LJ, 1'b1);
        stream("R8 short half zero fill", F_LJ, 14, 18, 18, 18'h3FFFF, 18'h2AAAA, 18'h3FFFF, 18'h1FFFF);
    endtask

    task automatic t_dsp_reset();
        int l0;
        int r0;
        do_reset(F_DSP, 1'b1);
        send_half(F_DSP, 1, 18'h11111, 18, 20);
        do_reset(F_DSP, 1'b1);
        l0 = n_left; r0 = n_right;
        send_half(F_DSP, 1, 18'h2468A, 18, 20);
        send_half(F_DSP, 0, 18'h13579, 18, 20);
        send_half(F_DSP, 1, 18'h0, 18, 20);
        repeat (10) @(negedge clk);
        check("R10 dsp tracker left after reset", last_left, 18'h2468A);
        check("R10 dsp tracker right follows", last_right, 18'h13579);
        check("R10 dsp counts", {16'(n_left - l0), 16'(n_right - r0)}, {16'd1, 16'd1});
    endtask

    task automatic t_mode_change();
        int l0;
        int r0;
        do_reset(F_LJ, 1'b1);
        l0 = n_left; r0 = n_right;
        send_half(F_LJ, 0, 18'h11111, 18, 24);
        send_half(F_LJ, 1, 18'h2C3A1, 18, 24);
        fmt_i = 2'(F_I2S);
        send_half(F_LJ, 0, 18'h3E1F0, 18, 24);
        send_half(F_I2S, 1, 18'h12345, 18, 24);
        send_half(F_I2S, 0, 18'h23456, 18, 24);
        send_half(F_I2S, 1, 18'h34567, 18, 24);
        send_half(F_I2S, 0, 18'h05A5A, 18, 24);
        send_half(F_I2S, 1, 18'h0, 18, 24);
        repeat (10) @(negedge clk);
        check("R11 first left before change", n_left - l0, 2);
        check("R11 partial right discarded", n_right - r0, 1);
        check("R11 left under new format", last_left, 18'h34567);
        check("R11 right under new format", last_right, 18'h05A5A);
    endtask

    initial begin
        t_reset();
        t_i2s();
        t_lj();
        t_dsp();
        t_packed();
        t_packed_force();
        t_extra();
        t_short();
        t_dsp_reset();
        t_mode_change();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog R9 actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule